// File: doc/BRIEF.md
# Unavailable State Detector

This block follows the availability of one line for performance monitoring. Once per second a strobe arrives with two flags that classify the second just ended: errored, and severely errored. Classifying the second is done elsewhere. The block keeps an unavailable-state bit and two running counters, one for errored seconds and one for severely errored seconds.

The line becomes unavailable after an unbroken run of severely errored seconds. It becomes available again after an unbroken run of seconds that were not severely errored. The entry run and the exit run each have their own length parameter, and both default to ten. While the line is unavailable, neither counter advances. A clear input zeroes both counters and leaves the state bit alone.

Top module: `ua_state_detector`

## Requirements
- R1: After reset, `unavail_o` is 0 and both counters read 0.
- R2: When a strobed second is severely errored and it completes ENTER_RUN (default 10) consecutive strobed severely errored seconds, `unavail_o` reads 1 on the clock edge that samples that strobe.
- R3: While the line is available, a strobed second with `ses_i`=0 restarts the entry run. Nine severely errored seconds, then one that is not, then nine more, leave `unavail_o` at 0.
- R4: While the line is unavailable, a strobed second with `ses_i`=0 that completes EXIT_RUN (default 10) consecutive such seconds returns `unavail_o` to 0 on the edge that samples it. An errored second and a clean second both count toward this run.
- R5: While the line is unavailable, a strobed second with `ses_i`=1 restarts the exit run.
- R6: On a strobe taken while `unavail_o` is 0, `es_cnt_o` increments if `es_i` or `ses_i` is 1, and `ses_cnt_o` increments if `ses_i` is 1. The strobe that causes entry is therefore counted, and the strobe that causes exit is not.
- R7: While `unavail_o` is 1, neither counter changes, except through a clear.
- R8: Each CNT_W-bit counter (default 16) saturates at its all-ones value (65535) and does not wrap.
- R9: `clr_i` zeroes both counters on the next edge and takes priority over a strobe in the same cycle. It does not change `unavail_o`.
- R10: When `sec_tick_i` is 0, the values of `es_i` and `ses_i` have no effect on the state or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle strobe, once per second |
| es_i | input | 1 | The strobed second was errored |
| ses_i | input | 1 | The strobed second was severely errored |
| clr_i | input | 1 | Zero both counters |
| unavail_o | output | 1 | Line is in the unavailable state |
| es_cnt_o | output | CNT_W | Errored-second count |
| ses_cnt_o | output | CNT_W | Severely-errored-second count |

## Verification
The assertions judge the flags only in a cycle where `sec_tick_i` is high. They allow `sec_tick_i` in any cycle, including back-to-back cycles, and they allow `clr_i` in any cycle, including together with a strobe. The assertions that tie a state change to the strobe that caused it assume the flags are stable at the sampling edge.

The bench changes its inputs only on falling edges. It holds garbage on the flags while the strobe is low, to show those values are ignored. It strobes on every cycle for long runs so that saturation can be reached quickly. It also issues a clear both while the line is unavailable and in the same cycle as a strobe.

// File: rtl/ua_pkg.sv
package ua_pkg;
  localparam int unsigned UA_DEF_ENTER = 10;
  localparam int unsigned UA_DEF_EXIT  = 10;
  localparam int unsigned UA_DEF_CNT_W = 16;

  typedef enum logic {
    UA_AVAIL   = 1'b0,
    UA_UNAVAIL = 1'b1
  } ua_state_e;
endpackage

// File: rtl/ua_run_det.sv
// Consecutive-run detector: done_o pulses on the strobe that completes LEN qualifying steps.
module ua_run_det #(
  parameter int unsigned LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic step_i,
  input  logic qual_i,
  output logic done_o
);
  localparam int unsigned RW = $clog2(LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(LEN - 1);

  logic [RW-1:0] run_q;

  assign done_o = en_i && step_i && qual_i && (run_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (!en_i) begin
      run_q <= '0;
    end else if (step_i) begin
      if (!qual_i || done_o) run_q <= '0;
      else                   run_q <= run_q + 1'b1;
    end
  end

  AST_RUN_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && step_i && !qual_i |=> run_q == '0); // R3
endmodule

// File: rtl/ua_sat_cnt.sv
module ua_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == MAX && !clr_i |=> cnt_q == MAX); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/ua_state_detector.sv
module ua_state_detector
  import ua_pkg::*;
#(
  parameter int unsigned ENTER_RUN = UA_DEF_ENTER,
  parameter int unsigned EXIT_RUN  = UA_DEF_EXIT,
  parameter int unsigned CNT_W     = UA_DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_tick_i,
  input  logic             es_i,
  input  logic             ses_i,
  input  logic             clr_i,
  output logic             unavail_o,
  output logic [CNT_W-1:0] es_cnt_o,
  output logic [CNT_W-1:0] ses_cnt_o
);
  ua_state_e state_q;
  logic      is_avail, enter_hit, exit_hit;
  logic      es_inc, ses_inc;

  assign is_avail = (state_q == UA_AVAIL);

  ua_run_det #(.LEN(ENTER_RUN)) u_enter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (is_avail),
    .step_i(sec_tick_i),
    .qual_i(ses_i),
    .done_o(enter_hit)
  );

  ua_run_det #(.LEN(EXIT_RUN)) u_exit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!is_avail),
    .step_i(sec_tick_i),
    .qual_i(!ses_i),
    .done_o(exit_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= UA_AVAIL;
    else if (enter_hit) state_q <= UA_UNAVAIL;
    else if (exit_hit)  state_q <= UA_AVAIL;
  end

  // counting uses the state before the strobe
  assign es_inc  = sec_tick_i && is_avail && (es_i || ses_i);
  assign ses_inc = sec_tick_i && is_avail && ses_i;

  ua_sat_cnt #(.W(CNT_W)) u_es_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .inc_i (es_inc),
    .cnt_o (es_cnt_o)
  );

  ua_sat_cnt #(.W(CNT_W)) u_ses_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .inc_i (ses_inc),
    .cnt_o (ses_cnt_o)
  );

  assign unavail_o = !is_avail;

  AST_ENTRY_ON_SES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unavail_o) |-> $past(sec_tick_i && ses_i)); // R2
  AST_EXIT_ON_NON_SES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unavail_o) |-> $past(sec_tick_i && !ses_i)); // R4
  AST_COUNTS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o && !clr_i |=> $stable(es_cnt_o) && $stable(ses_cnt_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_i && !clr_i |=> $stable(unavail_o) && $stable(es_cnt_o) && $stable(ses_cnt_o)); // R10
  AST_CLEAR_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !sec_tick_i |=> $stable(unavail_o)); // R9
endmodule

// File: tb/tb_ua_state_detector.sv
module tb_ua_state_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, es = 1'b0, ses = 1'b0, clr = 1'b0;
  logic        unavail;
  logic [15:0] es_cnt, ses_cnt;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  ua_state_detector dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .es_i(es), .ses_i(ses),
    .clr_i(clr), .unavail_o(unavail), .es_cnt_o(es_cnt), .ses_cnt_o(ses_cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // n back-to-back strobes with fixed flags, inputs move on falling edges
  task automatic ticks(input int n, input logic e, input logic s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1; es = e; ses = s;
    end
    @(negedge clk);
    tick = 1'b0; es = 1'b0; ses = 1'b0;
  endtask

  task automatic chk_all(input string tag, input logic u, input int e, input int s);
    chk({tag, " unavail"}, 32'(unavail), 32'(u));
    chk({tag, " es_cnt"}, 32'(es_cnt), 32'(e));
    chk({tag, " ses_cnt"}, 32'(ses_cnt), 32'(s));
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 1'b0, 0, 0);
  endtask

  task automatic t_count();
    ticks(3, 1'b1, 1'b0);
    ticks(2, 1'b0, 1'b1);
    ticks(1, 1'b0, 1'b0);
    chk_all("R6 counting", 1'b0, 5, 2);
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      es = 1'b1; ses = 1'b1;
    end
    @(negedge clk);
    es = 1'b0; ses = 1'b0;
    chk_all("R10 no strobe", 1'b0, 5, 2);
  endtask

  task automatic t_entry();
    ticks(9, 1'b0, 1'b1);
    ticks(1, 1'b1, 1'b0);
    ticks(9, 1'b0, 1'b1);
    chk_all("R3 entry run broken", 1'b0, 24, 20);
    ticks(1, 1'b0, 1'b1);
    chk_all("R2 entry on tenth", 1'b1, 25, 21);
  endtask

  task automatic t_exit();
    ticks(4, 1'b1, 1'b0);
    ticks(3, 1'b0, 1'b1);
    chk_all("R7 inhibited", 1'b1, 25, 21);
    ticks(5, 1'b1, 1'b0);
    ticks(4, 1'b0, 1'b0);
    ticks(1, 1'b0, 1'b1);
    ticks(9, 1'b1, 1'b0);
    chk_all("R5 exit run broken", 1'b1, 25, 21);
    ticks(1, 1'b0, 1'b0);
    chk_all("R4 exit on tenth", 1'b0, 25, 21);
    ticks(1, 1'b1, 1'b0);
    chk_all("R6 counting resumes", 1'b0, 26, 21);
  endtask

  task automatic t_clear();
    ticks(10, 1'b0, 1'b1);
    chk_all("R2 re-entry", 1'b1, 36, 31);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk_all("R9 clear while unavailable", 1'b1, 0, 0);
    ticks(10, 1'b0, 1'b0);
    chk_all("R4 exit after clear", 1'b0, 0, 0);
    @(negedge clk); clr = 1'b1; tick = 1'b1; ses = 1'b1;
    @(negedge clk); clr = 1'b0; tick = 1'b0; ses = 1'b0;
    chk_all("R9 clear beats strobe", 1'b0, 0, 0);
  endtask

  task automatic t_saturate();
    ticks(65534, 1'b1, 1'b0);
    chk_all("R8 one below max", 1'b0, 65534, 0);
    ticks(4, 1'b1, 1'b0);
    chk_all("R8 saturated", 1'b0, 65535, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_ignore();
    t_entry();
    t_exit();
    t_clear();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule